// File: doc/BRIEF.md
# LIN Status and Interrupt Flag Unit

This block holds the sticky event flags of a LIN serial controller and turns them into one interrupt request. A frame engine beside it delivers single-cycle strobes: a wake-up character arrived, a slave response timed out, a CRC or checksum comparison finished, the last byte of a frame was handled, and a receive byte was loaded into or read out of the receive data register. The unit qualifies each strobe with its LIN condition: sleep mode for wake-up, per-frame check enables for CRC and checksum. It also watches the receive line for a bus that stays stuck while a transmission is running, and for a receive byte that is overwritten before it has been read.

Software reaches two 32-bit words through a simple write/read port. One is the status word, where each flag is cleared by writing a 1 to its bit. The other is the enable word, which holds one interrupt enable per flag. The interrupt output is a registered level. It is high while any flag is set together with its enable. There is no streaming data path. Every pin is a plain control or status signal, and the port has no back-pressure.

Top module: `lin_stat_irq`

## Requirements
- R1: After reset the status word, the enable word and `irq_o` are all zero. Status and enable bits other than 18 to 23 and 31 always read 0.
- R2: A status write (`reg_sel_i`=0) clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R3: When a set event and a write-1-to-clear hit the same flag in the same cycle, the flag ends up set.
- R4: Bit 18 (wake) sets on `wake_char_i` only while `bus_asleep_i` is 1. A wake-up strobe outside sleep leaves bit 18 at 0.
- R5: Bit 19 (slave timeout) sets on `slave_tmo_i`.
- R6: Bit 21 (CRC error) sets on `crc_done_i` only when `crc_chk_en_i` and `crc_mismatch_i` are both 1.
- R7: Bit 22 (checksum error) sets on `sum_done_i` only when `sum_chk_en_i` and `sum_mismatch_i` are both 1.
- R8: Bit 23 (frame complete) sets on `frame_last_i`.
- R9: Bit 31 (overflow) sets when `rxb_load_i` arrives while the previous byte is still unread. A load in the same cycle as a read does not count as an overflow.
- R10: While `tx_busy_i` is 1, bit 20 (bus stuck) sets on the 15th `bit_tick_i` with `rxd_i` unchanged. Any `rxd_i` edge restarts the count. While `tx_busy_i` is 0, the count stays at zero.
- R11: An enable write (`reg_sel_i`=1) loads the enable bits at positions 18 to 23 and 31. `reg_rdata_o` returns the enable word while `reg_sel_i`=1 and the status word while `reg_sel_i`=0.
- R12: `irq_o` equals the OR over all flags of flag AND enable, taken from the previous cycle's register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_char_i | input | 1 | Wake-up character received strobe |
| bus_asleep_i | input | 1 | LIN bus is in sleep mode |
| slave_tmo_i | input | 1 | Slave response timeout strobe |
| crc_done_i | input | 1 | CRC comparison finished strobe |
| crc_chk_en_i | input | 1 | CRC checking enabled for this frame |
| crc_mismatch_i | input | 1 | Received CRC differs from computed value |
| sum_done_i | input | 1 | Checksum comparison finished strobe |
| sum_chk_en_i | input | 1 | Checksum checking enabled for this frame |
| sum_mismatch_i | input | 1 | Received checksum differs from computed value |
| frame_last_i | input | 1 | Last byte of a frame sent or received |
| rxb_load_i | input | 1 | Receive data register loaded with a new byte |
| rxb_read_i | input | 1 | Receive data register read by the system |
| tx_busy_i | input | 1 | Transmission in progress |
| rxd_i | input | 1 | Receive line level |
| bit_tick_i | input | 1 | One pulse per bit time |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Word select: 0 status, 1 enable |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected word |
| irq_o | output | 1 | Interrupt request, active-high level |

## Verification
Each flag shows in `reg_rdata_o` after the first rising edge that samples its strobe. The stuck-bus flag appears after the edge that samples the 15th tick. `irq_o` changes one edge after the flag or enable that causes it. The bench drives inputs on falling edges and reads on the next falling edge. For the interrupt it checks both the cycle where the level must still be low and the cycle where it must be high. Each table entry first clears all flags and then applies one strobe pattern, so a flag left over from an earlier entry cannot hide a missing or a spurious set.

// File: rtl/lin_stat_pkg.sv
package lin_stat_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned NFLAG  = 7;

  // flag slots inside the flag bank
  localparam int unsigned F_WAKE = 0;
  localparam int unsigned F_STO  = 1;
  localparam int unsigned F_BUS  = 2;
  localparam int unsigned F_CRC  = 3;
  localparam int unsigned F_SUM  = 4;
  localparam int unsigned F_DONE = 5;
  localparam int unsigned F_OVF  = 6;

  // software-visible bit of each slot
  localparam int unsigned FLAG_POS [NFLAG] = '{18, 19, 20, 21, 22, 23, 31};

  function automatic logic [WORD_W-1:0] flag_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int k = 0; k < int'(NFLAG); k++) m[FLAG_POS[k]] = 1'b1;
    return m;
  endfunction

  localparam logic [WORD_W-1:0] FLAG_MASK = flag_mask();

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ENABLE = 1'b1
  } word_sel_e;
endpackage

// File: rtl/lin_bus_monitor.sv
module lin_bus_monitor #(
  parameter int unsigned STUCK_BITS = 15,
  localparam int unsigned CW = $clog2(STUCK_BITS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_busy_i,
  input  logic rxd_i,
  input  logic bit_tick_i,
  output logic stuck_o
);
  localparam logic [CW-1:0] LIMIT = CW'(STUCK_BITS);

  logic          rxd_q;
  logic [CW-1:0] cnt_q;
  logic          edge_w;

  assign edge_w = rxd_i ^ rxd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      rxd_q <= rxd_i;
      if (!tx_busy_i || edge_w)
        cnt_q <= '0;
      else if (bit_tick_i && cnt_q != LIMIT)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  // one pulse when the count reaches the limit; saturation prevents repeats
  assign stuck_o = tx_busy_i & ~edge_w & bit_tick_i & (cnt_q == LIMIT - 1'b1);

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
  // R10
  edge_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy_i && rxd_i != rxd_q) |=> cnt_q == '0);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy_i |=> cnt_q == '0);
endmodule

// File: rtl/lin_rx_overrun.sv
module lin_rx_overrun (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic read_i,
  output logic ovf_o
);
  logic full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= load_i | (full_q & ~read_i);
  end

  assign ovf_o = load_i & full_q & ~read_i;

  // R9
  load_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> full_q);
  // R9
  read_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (read_i && !load_i) |=> !full_q);
endmodule

// File: rtl/lin_flag_bank.sv
module lin_flag_bank #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (set_i[k]) q <= 1'b1;
      else if (clr_i[k]) q <= 1'b0;
    end
    assign flag_o[k] = q;

    // R3
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[k] |=> flag_o[k]);
    // R2
    clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[k] && !set_i[k]) |=> !flag_o[k]);
    // R2
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[k] && !set_i[k]) |=> $stable(flag_o[k]));
  end
endmodule

// File: rtl/lin_irq_reduce.sv
module lin_irq_reduce #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(flag_i & en_i);
  end

  // R12
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_i & en_i)) |=> irq_o);
  // R12
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flag_i & en_i)) |=> !irq_o);
endmodule

// File: rtl/lin_stat_irq.sv
module lin_stat_irq
  import lin_stat_pkg::*;
#(
  parameter int unsigned STUCK_BITS = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wake_char_i,
  input  logic              bus_asleep_i,
  input  logic              slave_tmo_i,
  input  logic              crc_done_i,
  input  logic              crc_chk_en_i,
  input  logic              crc_mismatch_i,
  input  logic              sum_done_i,
  input  logic              sum_chk_en_i,
  input  logic              sum_mismatch_i,
  input  logic              frame_last_i,
  input  logic              rxb_load_i,
  input  logic              rxb_read_i,
  input  logic              tx_busy_i,
  input  logic              rxd_i,
  input  logic              bit_tick_i,
  input  logic              reg_wr_i,
  input  logic              reg_sel_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [NFLAG-1:0]  set_v, clr_v, flags, en_q, en_d;
  logic              stuck_evt, ovf_evt, wr_stat, wr_en;
  logic [WORD_W-1:0] stat_word, en_word;
  logic              unused_wbits;

  assign wr_stat = reg_wr_i & (word_sel_e'(reg_sel_i) == SEL_STATUS);
  assign wr_en   = reg_wr_i & (word_sel_e'(reg_sel_i) == SEL_ENABLE);
  assign unused_wbits = ^(reg_wdata_i & ~FLAG_MASK);

  lin_bus_monitor #(.STUCK_BITS(STUCK_BITS)) u_bus (
    .clk(clk), .rst_n(rst_n), .tx_busy_i(tx_busy_i), .rxd_i(rxd_i),
    .bit_tick_i(bit_tick_i), .stuck_o(stuck_evt)
  );

  lin_rx_overrun u_ovr (
    .clk(clk), .rst_n(rst_n), .load_i(rxb_load_i), .read_i(rxb_read_i),
    .ovf_o(ovf_evt)
  );

  always_comb begin
    set_v         = '0;
    set_v[F_WAKE] = wake_char_i & bus_asleep_i;
    set_v[F_STO]  = slave_tmo_i;
    set_v[F_BUS]  = stuck_evt;
    set_v[F_CRC]  = crc_done_i & crc_chk_en_i & crc_mismatch_i;
    set_v[F_SUM]  = sum_done_i & sum_chk_en_i & sum_mismatch_i;
    set_v[F_DONE] = frame_last_i;
    set_v[F_OVF]  = ovf_evt;
  end

  for (genvar k = 0; k < NFLAG; k++) begin : g_map
    assign clr_v[k] = wr_stat & reg_wdata_i[FLAG_POS[k]];
    assign en_d[k]  = reg_wdata_i[FLAG_POS[k]];
  end

  lin_flag_bank #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v), .flag_o(flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= en_d;
  end

  always_comb begin
    stat_word = '0;
    en_word   = '0;
    for (int k = 0; k < int'(NFLAG); k++) begin
      stat_word[FLAG_POS[k]] = flags[k];
      en_word[FLAG_POS[k]]   = en_q[k];
    end
  end

  assign reg_rdata_o = reg_sel_i ? en_word : stat_word;

  lin_irq_reduce #(.N(NFLAG)) u_irq (
    .clk(clk), .rst_n(rst_n), .flag_i(flags), .en_i(en_q), .irq_o(irq_o)
  );

  // R4
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_char_i && !bus_asleep_i && !flags[F_WAKE]) |=> !flags[F_WAKE]);
  // R6
  crc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!crc_chk_en_i && !flags[F_CRC]) |=> !flags[F_CRC]);
  // R7
  sum_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sum_chk_en_i && !flags[F_SUM]) |=> !flags[F_SUM]);
  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata_o & ~FLAG_MASK) == '0);
endmodule

// File: tb/lin_stat_irq_tb.sv
module lin_stat_irq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wake, asleep, tmo, crc_d, crc_en, crc_bad, sum_d, sum_en, sum_bad, last;
  logic load, rd, txb, rxd, tick, wr, sel;
  logic [31:0] wdata, rdata;
  logic irq;
  int nchk = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  lin_stat_irq u_dut (
    .clk(clk), .rst_n(rst_n), .wake_char_i(wake), .bus_asleep_i(asleep),
    .slave_tmo_i(tmo), .crc_done_i(crc_d), .crc_chk_en_i(crc_en),
    .crc_mismatch_i(crc_bad), .sum_done_i(sum_d), .sum_chk_en_i(sum_en),
    .sum_mismatch_i(sum_bad), .frame_last_i(last), .rxb_load_i(load),
    .rxb_read_i(rd), .tx_busy_i(txb), .rxd_i(rxd), .bit_tick_i(tick),
    .reg_wr_i(wr), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // ctrl bits: 9 wake,8 asleep,7 tmo,6 crc_d,5 crc_en,4 crc_bad,3 sum_d,2 sum_en,1 sum_bad,0 last
  typedef logic [41:0] vec_t;
  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    {10'b11_0000_0000, 32'h0004_0000},  // R4 wake in sleep
    {10'b10_0000_0000, 32'h0000_0000},  // R4 wake outside sleep
    {10'b01_0000_0000, 32'h0000_0000},  // R4 sleep alone
    {10'b00_1000_0000, 32'h0008_0000},  // R5 timeout
    {10'b00_0111_0000, 32'h0020_0000},  // R6 crc checked, bad
    {10'b00_0110_0000, 32'h0000_0000},  // R6 crc checked, good
    {10'b00_0101_0000, 32'h0000_0000},  // R6 crc unchecked, bad
    {10'b00_0000_1110, 32'h0040_0000},  // R7 sum checked, bad
    {10'b00_0000_1010, 32'h0000_0000},  // R7 sum unchecked, bad
    {10'b00_0000_0001, 32'h0080_0000},  // R8 last byte
    {10'b00_1000_1111, 32'h00C8_0000}   // R5 R7 R8 together
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic wreg(input logic s, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; sel = s; wdata = d;
    @(negedge clk); wr = 1'b0; sel = 1'b0; wdata = '0;
  endtask

  function automatic logic [31:0] status_now();
    return rdata;
  endfunction

  task automatic set_ctrl(input logic [9:0] c);
    {wake, asleep, tmo, crc_d, crc_en, crc_bad, sum_d, sum_en, sum_bad, last} = c;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    set_ctrl('0); load = 0; rd = 0; txb = 0; rxd = 1; tick = 0;
    wr = 0; sel = 0; wdata = '0;
    repeat (3) cyc();
    #1;
    chk("R1 status at reset", rdata, 32'h0);
    chk("R1 irq at reset", {31'h0, irq}, 32'h0);
    sel = 1; #1;
    chk("R1 enable at reset", rdata, 32'h0);
    sel = 0;
    cyc(); rst_n = 1'b1;

    // table walk: clear, one strobe cycle, read status
    for (int i = 0; i < NV; i++) begin
      wreg(1'b0, 32'hFFFF_FFFF);
      set_ctrl(VECS[i][41:32]);
      cyc();
      set_ctrl('0);
      #1;
      chk($sformatf("R4-8 vector %0d (R5 R6 R7 R8)", i), status_now(), VECS[i][31:0]);
    end

    // R2: write-0 keeps, write-1 clears
    wreg(1'b0, 32'hFFFF_FFFF);
    last = 1; cyc(); last = 0;
    wreg(1'b0, 32'h0000_0000); #1;
    chk("R2 write zero keeps flag", rdata, 32'h0080_0000);
    wreg(1'b0, 32'h0008_0000); #1;
    chk("R2 other bit clear keeps flag", rdata, 32'h0080_0000);
    wreg(1'b0, 32'h0080_0000); #1;
    chk("R2 write one clears flag", rdata, 32'h0);

    // R3: set and clear together
    @(negedge clk); wr = 1; sel = 0; wdata = 32'h0080_0000; last = 1;
    @(negedge clk); wr = 0; wdata = '0; last = 0; #1;
    chk("R3 set wins over clear", rdata, 32'h0080_0000);
    wreg(1'b0, 32'hFFFF_FFFF);

    // R9 overflow
    load = 1; cyc(); cyc(); load = 0; #1;
    chk("R9 second load unread", rdata, 32'h8000_0000);
    wreg(1'b0, 32'hFFFF_FFFF);
    rd = 1; cyc(); rd = 0;
    load = 1; cyc(); load = 0;
    rd = 1; cyc(); rd = 0;
    load = 1; cyc(); load = 0; #1;
    chk("R9 read between loads", rdata, 32'h0);
    load = 1; rd = 1; cyc(); load = 0; rd = 0; #1;
    chk("R9 load with read same cycle", rdata, 32'h0);
    load = 1; cyc(); load = 0; #1;
    chk("R9 load while full", rdata, 32'h8000_0000);
    rd = 1; cyc(); rd = 0;
    wreg(1'b0, 32'hFFFF_FFFF);

    // R10 stuck bus
    txb = 1; tick = 1; rxd = 1;
    repeat (14) cyc(); #1;
    chk("R10 after 14 ticks", rdata, 32'h0);
    cyc(); #1;
    chk("R10 after 15 ticks", rdata, 32'h0010_0000);
    wreg(1'b0, 32'hFFFF_FFFF); #1;
    chk("R10 saturated no reset", rdata, 32'h0);
    rxd = 0;
    repeat (15) cyc(); #1;
    chk("R10 edge restarts count", rdata, 32'h0);
    cyc(); #1;
    chk("R10 15 ticks after edge", rdata, 32'h0010_0000);
    wreg(1'b0, 32'hFFFF_FFFF);
    txb = 0;
    repeat (20) cyc(); #1;
    chk("R10 idle without transmission", rdata, 32'h0);
    tick = 0; rxd = 1;

    // R11 enable word
    wreg(1'b1, 32'hFFFF_FFFF);
    sel = 1; #1;
    chk("R11 enable readback", rdata, 32'h80FC_0000);
    sel = 0;

    // R12 interrupt timing
    wreg(1'b0, 32'hFFFF_FFFF);
    last = 1; cyc(); last = 0; #1;
    chk("R12 irq not yet", {31'h0, irq}, 32'h0);
    cyc(); #1;
    chk("R12 irq one cycle later", {31'h0, irq}, 32'h1);
    wreg(1'b1, 32'h0008_0000); #1;
    chk("R12 irq still from old enable", {31'h0, irq}, 32'h1);
    cyc(); #1;
    chk("R12 irq masked", {31'h0, irq}, 32'h0);
    tmo = 1; cyc(); tmo = 0; cyc(); #1;
    chk("R12 irq from enabled flag", {31'h0, irq}, 32'h1);

    finish_run();
  end
endmodule